// File: doc/BRIEF.md
# DRAM Byte Parity Generator and Checker

This block sits between a 16-bit processor data path and an 18-bit memory bank that holds two data bytes, each paired with its own parity bit. On a write it drives an odd parity bit for every byte lane and marks which lanes' parity bits are to be stored, so each written byte ends up with an odd count of ones across its data and parity bit. On a read it recomputes the parity of each enabled byte and compares it with the stored bit returned by the memory.

A mismatch in any enabled lane sets a sticky per-lane error flag and a summary parity-error flag. A non-maskable interrupt request follows the summary flag as a level unless either of two independent disable bits is set: one from a configuration register and one from a system control port. A system built without parity storage sets one of these bits so that the missing parity never raises an interrupt. The error flags stay set until an explicit clear pulse or reset.

Top module: `parityGuard`

## Requirements
- R1: Byte lane i is data bits [8i+7:8i], with lane 0 the low byte. parOut[i] is chosen so that the lane's eight write-data bits plus parOut[i] hold an odd number of ones. parWe[i] is high exactly when wrStrobe and byteEn[i] are both high.
- R2: A lane holding 8'hFF gives parOut 1. A lane holding 8'h00 gives parOut 1. A lane holding 8'h01 gives parOut 0.
- R3: When rdStrobe is high at a rising clock edge and byteEn[i] is high, errByte[i] sets at that edge if the lane's read data plus parIn[i] hold an even number of ones. parErr is the OR of errByte and is visible after that same edge.
- R4: A lane whose byteEn bit is low during a read never sets its errByte bit, whatever its data and parity.
- R5: errByte bits are sticky. They hold through idle cycles and good reads, and clear at the edge where errClear is high.
- R6: When errClear and a read mismatch fall on the same edge, errByte takes exactly the lanes that fail in that read, and earlier errors are dropped.
- R7: nmiReq is high exactly while parErr is high and both cfgNmiOff and portNmiOff are low, and it follows those inputs combinationally. errByte and parErr still set while either disable bit is high.
- R8: After reset, errByte, parErr and nmiReq are all 0.
- R9: Without rdStrobe and errClear, errByte does not change, whatever rdData and parIn carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | Write cycle in progress |
| rdStrobe | input | 1 | Read data and parity valid, sampled at the edge |
| byteEn | input | 2 | Byte lane enables |
| wrData | input | 16 | Data being written to memory |
| rdData | input | 16 | Data read back from memory |
| parIn | input | 2 | Stored parity bits read back, one per lane |
| errClear | input | 1 | Clear pulse for the error flags |
| cfgNmiOff | input | 1 | Configuration disable bit for the interrupt |
| portNmiOff | input | 1 | Control-port disable bit for the interrupt |
| parOut | output | 2 | Generated parity bits for writing, one per lane |
| parWe | output | 2 | Per-lane parity store enable |
| errByte | output | 2 | Sticky per-lane parity error |
| parErr | output | 1 | Summary parity error |
| nmiReq | output | 1 | Non-maskable interrupt request level |

## Verification
A clear pulse and a failing read can land on the same edge. The bench provokes this with both kinds of earlier error state: a flag already set in one lane while the new failure is in the other lane, and a flag already set in the same lane. It judges the result against the replace rule for errByte. The interrupt disable bits are also toggled in the same cycle a flag first sets, to show that the flag records the error while nmiReq stays low.

// File: rtl/parityGuardPkg.sv
package parityGuardPkg;
  // Strobes from control to datapath, one cycle's worth of intent.
  typedef struct packed {
    logic storeWrite;
    logic checkRead;
  } pathStrobe_t;
endpackage

// File: rtl/parityGuardPath.sv
module parityGuardPath
  import parityGuardPkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  pathStrobe_t       strobe,
  input  logic [LANES-1:0]  byteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANES-1:0]  parIn,
  output logic [LANES-1:0]  parOut,
  output logic [LANES-1:0]  parWe,
  output logic [LANES-1:0]  mismatch
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic wrEven;
    logic rdOdd;
    assign wrEven      = ~(^wrData[g*LANE_W +: LANE_W]);
    assign rdOdd       = ^{rdData[g*LANE_W +: LANE_W], parIn[g]};
    assign parOut[g]   = wrEven;
    assign parWe[g]    = strobe.storeWrite & byteEn[g];
    assign mismatch[g] = strobe.checkRead & byteEn[g] & ~rdOdd;
  end
endmodule

// File: rtl/parityGuardCtrl.sv
module parityGuardCtrl
  import parityGuardPkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  input  logic             errClear,
  input  logic             cfgNmiOff,
  input  logic             portNmiOff,
  input  logic [LANES-1:0] mismatch,
  output pathStrobe_t      strobe,
  output logic [LANES-1:0] errByte,
  output logic             parErr,
  output logic             nmiReq
);
  logic [LANES-1:0] errQ;
  logic             nmiGate;

  always_comb begin
    strobe            = '0;
    strobe.storeWrite = wrStrobe;
    strobe.checkRead  = rdStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         errQ <= '0;
    else if (errClear) errQ <= mismatch;
    else               errQ <= errQ | mismatch;
  end

  assign nmiGate = ~(cfgNmiOff | portNmiOff);
  assign errByte = errQ;
  assign parErr  = |errQ;
  assign nmiReq  = parErr & nmiGate;
endmodule

// File: rtl/parityGuard.sv
module parityGuard
  import parityGuardPkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [LANES-1:0]  byteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANES-1:0]  parIn,
  input  logic              errClear,
  input  logic              cfgNmiOff,
  input  logic              portNmiOff,
  output logic [LANES-1:0]  parOut,
  output logic [LANES-1:0]  parWe,
  output logic [LANES-1:0]  errByte,
  output logic              parErr,
  output logic              nmiReq
);
  pathStrobe_t      strobe;
  logic [LANES-1:0] mismatch;

  parityGuardCtrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .errClear(errClear), .cfgNmiOff(cfgNmiOff), .portNmiOff(portNmiOff),
    .mismatch(mismatch), .strobe(strobe), .errByte(errByte),
    .parErr(parErr), .nmiReq(nmiReq)
  );

  parityGuardPath #(.LANES(LANES), .LANE_W(LANE_W)) u_path (
    .strobe(strobe), .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .parIn(parIn), .parOut(parOut), .parWe(parWe), .mismatch(mismatch)
  );
endmodule

// File: rtl/parityGuardChk.sv
module parityGuardChk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic [LANES-1:0]  byteEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [LANES-1:0]  parIn,
  input logic              errClear,
  input logic              cfgNmiOff,
  input logic              portNmiOff,
  input logic [LANES-1:0]  parOut,
  input logic [LANES-1:0]  parWe,
  input logic [LANES-1:0]  errByte,
  input logic              parErr,
  input logic              nmiReq
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    p_odd_write_r1: assert property (@(posedge clk) disable iff (!rstN)
      ($countones({wrData[g*LANE_W +: LANE_W], parOut[g]}) % 2) == 1);
    p_lane_off_r4: assert property (@(posedge clk) disable iff (!rstN)
      rdStrobe && !byteEn[g] && (!errByte[g] || errClear) |=> !errByte[g]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      errByte[g] && !errClear |=> errByte[g]);
    p_detect_r3: assert property (@(posedge clk) disable iff (!rstN)
      rdStrobe && byteEn[g] &&
      ($countones({rdData[g*LANE_W +: LANE_W], parIn[g]}) % 2) == 0 |=> errByte[g]);
  end

  p_no_store_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> parWe == '0);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    errClear && !rdStrobe |=> errByte == '0);
  p_nmi_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> parErr && !cfgNmiOff && !portNmiOff);
  p_nmi_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    parErr && !cfgNmiOff && !portNmiOff |-> nmiReq);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe && !errClear |=> $stable(errByte));
endmodule

bind parityGuard parityGuardChk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/test_parityGuard.sv
`timescale 1ns/1ps
module test_parityGuard;
  logic clk = 0, rstN = 0;
  logic wrStrobe = 0, rdStrobe = 0, errClear = 0, cfgNmiOff = 0, portNmiOff = 0;
  logic [1:0] byteEn = 0, parIn = 0;
  logic [15:0] wrData = 0, rdData = 0;
  logic [1:0] parOut, parWe, errByte;
  logic parErr, nmiReq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] modelErr = 0;

  always #4 clk = ~clk;

  parityGuard i_parityGuard (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .parIn(parIn),
    .errClear(errClear), .cfgNmiOff(cfgNmiOff), .portNmiOff(portNmiOff),
    .parOut(parOut), .parWe(parWe), .errByte(errByte), .parErr(parErr),
    .nmiReq(nmiReq)
  );

  function automatic logic oddBit(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (b[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One clock of stimulus with full comparison against the model.
  task automatic cycle(input logic wr, input logic rd, input logic [1:0] be,
                       input logic [15:0] wd, input logic [15:0] rdd,
                       input logic [1:0] pin, input logic clr,
                       input logic cfg, input logic port, input string tag);
    logic [1:0] mis;
    logic [1:0] expPar;
    @(negedge clk);
    wrStrobe = wr; rdStrobe = rd; byteEn = be; wrData = wd; rdData = rdd;
    parIn = pin; errClear = clr; cfgNmiOff = cfg; portNmiOff = port;
    #1;
    expPar = {oddBit(wd[15:8]), oddBit(wd[7:0])};
    chk({tag, " R1 parOut"}, parOut, expPar);
    chk({tag, " R1 parWe"}, parWe, wr ? be : 2'b00);
    chk({tag, " R7 nmi comb"}, nmiReq, (modelErr != 0) && !cfg && !port);
    for (int i = 0; i < 2; i++)
      mis[i] = rd && be[i] && (oddBit(rdd[i*8 +: 8]) != pin[i]);
    @(posedge clk);
    modelErr = clr ? mis : (modelErr | mis);
    #1;
    chk({tag, " R3 R5 errByte"}, errByte, modelErr);
    chk({tag, " R3 parErr"}, parErr, modelErr != 0);
    chk({tag, " R7 nmi"}, nmiReq, (modelErr != 0) && !cfg && !port);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    chk("R8 reset errByte", errByte, 0);
    chk("R8 reset parErr", parErr, 0);
    chk("R8 reset nmi", nmiReq, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 R2 writes
    cycle(1, 0, 2'b11, 16'hFF00, 0, 0, 0, 0, 0, "R2 FF/00");
    chk("R2 FF high", parOut[1], 1);
    chk("R2 00 low", parOut[0], 1);
    cycle(1, 0, 2'b01, 16'h0001, 0, 0, 0, 0, 0, "R2 01");
    chk("R2 01 low", parOut[0], 0);
    cycle(1, 0, 2'b10, 16'hA55A, 0, 0, 0, 0, 0, "R1 half");
    cycle(0, 0, 2'b11, 16'h1234, 0, 0, 0, 0, 0, "R1 nowrite");

    // R3 good read, then bad low lane
    cycle(0, 1, 2'b11, 0, 16'hFF01, 2'b10, 0, 0, 0, "R3 good");
    cycle(0, 1, 2'b11, 0, 16'hFF01, 2'b11, 0, 0, 0, "R3 bad low");
    chk("R3 low flag", errByte, 2'b01);
    // R5 sticky across idle and good read; R9 bad data w/o strobe
    cycle(0, 0, 2'b11, 0, 16'h0000, 2'b00, 0, 0, 0, "R9 idle bad");
    cycle(0, 1, 2'b11, 0, 16'h0000, 2'b11, 0, 0, 0, "R5 good read");
    // R7 gating
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 cfg off");
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 port off");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 1, "R7 both off");
    // R5 clear
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 clear");
    chk("R5 cleared", errByte, 0);
    // R4 disabled lanes
    cycle(0, 1, 2'b00, 0, 16'h0000, 2'b00, 0, 0, 0, "R4 none enabled");
    cycle(0, 1, 2'b01, 0, 16'h0000, 2'b01, 0, 0, 0, "R4 high off");
    chk("R4 no flag", errByte, 0);
    // R7 error while suppressed
    cycle(0, 1, 2'b10, 0, 16'h0000, 2'b00, 0, 1, 0, "R7 set suppressed");
    chk("R7 flag while off", errByte, 2'b10);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 release");
    // R6 clear with new error, other lane
    cycle(0, 1, 2'b01, 0, 16'h0000, 2'b00, 1, 0, 0, "R6 clr+new other");
    chk("R6 replace", errByte, 2'b01);
    // R6 same lane
    cycle(0, 1, 2'b11, 0, 16'h0000, 2'b10, 1, 0, 0, "R6 clr+same");
    chk("R6 same lane", errByte, 2'b01);
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 clear2");

    // mixed traffic
    for (int n = 0; n < 300; n++) begin
      logic [15:0] d;
      logic [1:0] p;
      d = 16'($urandom);
      p = {oddBit(d[15:8]), oddBit(d[7:0])};
      if ($urandom_range(0, 5) == 0) p = p ^ 2'($urandom_range(1, 3));
      cycle(1'($urandom), 1'($urandom), 2'($urandom), 16'($urandom), d, p,
            $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 3) == 0, "R9 mix");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule